// File: doc/BRIEF.md
# Two-Wire Programming Command Engine

This block is the target-side sequencer of a two-wire in-circuit programming port. The external programmer supplies the serial clock (the block's `clk`) and a data line. The data line is split here into an input, an output value and an output enable, so that the pad ring can build the bidirectional pin. Every command begins with a short control code. One code loads a 24-bit instruction word and passes it to the CPU's execution interface. A second code returns the contents of a 16-bit visibility register to the programmer. All other codes are rejected.

After reset the engine behaves as if program-mode entry has just completed. It runs a longer forced execute command that issues a no-operation word, and then loads the first real instruction straight away. After each instruction is delivered, the engine gives the CPU a short execution window. During that same window it already shifts in the next control code, so the programmer never has to insert dead clocks.

Top module: `isp_cmd_engine`

## Requirements
- R1: After reset release the data line is ignored for 9 clocks. In the cycle after the 9th rising edge, `insn_valid` pulses for one cycle with `insn_word` equal to the no-operation word (all zeros). The next 24 clocks then load an instruction with no control code in front of it.
- R2: A control code of 0 (4 bits, least significant bit first) is followed by 24 instruction bits, least significant bit first. In the cycle after the edge that samples the 24th bit, `insn_valid` is high for exactly one cycle and `insn_word` holds the assembled word.
- R3: `cpu_hold` is high during the forced start and while instruction bits are being shifted, and low in every other phase.
- R4: `exec_busy` goes high in the cycle that `insn_valid` pulses for a shifted-in instruction and stays high for exactly 4 cycles. During those 4 cycles the next control code is sampled and acted on.
- R5: A control code of 1 starts a read-out. For 8 clocks `dat_oe` stays low. The visibility value is captured at the 8th edge. After the 8th edge and after each of the next 15 edges, `dat_out` shows bit k of that value, with k counting 0 to 15, and `dat_oe` is high.
- R6: `dat_oe` falls at the edge after the last read-out bit, one clock before the first bit of the next control code is sampled. It is never high outside a read-out data phase.
- R7: Control codes 2 to 15 raise `code_err` for one cycle. They produce no `insn_valid`, no `exec_busy` and no `dat_oe`, and the engine then fetches a fresh control code.
- R8: An asynchronous reset in the middle of any command returns the engine to the forced start, and the full R1 sequence repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial programming clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset (program-mode entry) |
| dat_in | input | 1 | Data line value as seen by the target |
| dat_out | output | 1 | Read-out bit to drive onto the data line |
| dat_oe | output | 1 | Output enable for the data line pad |
| vis_data | input | 16 | Visibility register contents from the CPU |
| insn_word | output | 24 | Instruction word presented to the CPU |
| insn_valid | output | 1 | One-cycle strobe qualifying `insn_word` |
| cpu_hold | output | 1 | Holds the CPU suspended while a word is loading |
| exec_busy | output | 1 | Execution window for the last delivered instruction |
| code_err | output | 1 | One-cycle flag for a reserved control code |

## Verification
A corrupted phase or bit counter is visible at the ports within one command. In that case `insn_valid` arrives a cycle early or late, or carries a rotated word, and the bench sees it on the strobe cycle. A misread control code shows up four clocks after the code starts. It appears as a missing `dat_oe`, a spurious `code_err`, or a `cpu_hold` that rises when it should not. An off-by-one in the read-out shifter shows as the wrong `dat_out` bit at the first data cycle. A late output-enable release is caught one clock after the last data bit.

// File: rtl/isp_cmd_pkg.sv
package isp_cmd_pkg;
   typedef enum logic [2:0] {
      PH_FORCE   = 3'd0,
      PH_CODE    = 3'd1,
      PH_INSN    = 3'd2,
      PH_RD_IDLE = 3'd3,
      PH_RD_DATA = 3'd4
   } phase_t;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/isp_shift_in.sv
module isp_shift_in #(
   parameter int W         = 24,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         bit_i,
   output logic [W-1:0] next_o
);
   logic [W-1:0] sr_q;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign next_o = {bit_i, sr_q[W-1:1]};
      end else begin : g_msb
         assign next_o = {sr_q[W-2:0], bit_i};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sr_q <= '0;
      else if (en) sr_q <= next_o;
   end
endmodule

// File: rtl/isp_shift_out.sv
module isp_shift_out #(
   parameter int W         = 16,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   output logic         bit_o
);
   logic [W-1:0] sr_q;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign bit_o = sr_q[0];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sr_q <= '0;
            else if (load)  sr_q <= load_val;
            else if (shift) sr_q <= {1'b0, sr_q[W-1:1]};
         end
      end else begin : g_msb
         assign bit_o = sr_q[W-1];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sr_q <= '0;
            else if (load)  sr_q <= load_val;
            else if (shift) sr_q <= {sr_q[W-2:0], 1'b0};
         end
      end
   endgenerate
endmodule

// File: rtl/isp_cmd_engine.sv
module isp_cmd_engine #(
   parameter int                 CODE_W       = 4,
   parameter int                 INSN_W       = 24,
   parameter int                 VIS_W        = 16,
   parameter int                 FORCE_CLKS   = 9,
   parameter int                 RD_IDLE_CLKS = 8,
   parameter bit                 LSB_FIRST    = 1'b1,
   parameter logic [INSN_W-1:0]  NOP_WORD     = '0,
   parameter logic [CODE_W-1:0]  CODE_EXEC    = '0,
   parameter logic [CODE_W-1:0]  CODE_READ    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dat_in,
   output logic              dat_out,
   output logic              dat_oe,
   input  logic [VIS_W-1:0]  vis_data,
   output logic [INSN_W-1:0] insn_word,
   output logic              insn_valid,
   output logic              cpu_hold,
   output logic              exec_busy,
   output logic              code_err
);
   import isp_cmd_pkg::*;

   localparam int MAX_LEN = max_of(max_of(max_of(FORCE_CLKS, CODE_W), max_of(INSN_W, VIS_W)),
                                   RD_IDLE_CLKS);
   localparam int CNT_W   = $clog2(MAX_LEN + 1);

   generate
      if (CODE_W < 2)              begin : g_bad_code  $error("CODE_W must be at least 2");            end
      if (VIS_W < 2)               begin : g_bad_vis   $error("VIS_W must be at least 2");             end
      if (INSN_W < 2)              begin : g_bad_insn  $error("INSN_W must be at least 2");            end
      if (FORCE_CLKS <= CODE_W)    begin : g_bad_force $error("FORCE_CLKS must exceed CODE_W");        end
      if (RD_IDLE_CLKS < 1)        begin : g_bad_idle  $error("RD_IDLE_CLKS must be at least 1");      end
      if (CODE_EXEC == CODE_READ)  begin : g_bad_map   $error("execute and read codes must differ");   end
   endgenerate

   phase_t             phase_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [CNT_W-1:0]   len_m1;
   logic               last;
   logic [CODE_W-1:0]  code_next;
   logic [INSN_W-1:0]  insn_next;
   logic               vis_bit;
   logic               oe_q;
   logic               valid_q;
   logic               busy_q;
   logic               err_q;
   logic [INSN_W-1:0]  word_q;

   always_comb begin
      unique case (phase_q)
         PH_FORCE:   len_m1 = CNT_W'(FORCE_CLKS - 1);
         PH_CODE:    len_m1 = CNT_W'(CODE_W - 1);
         PH_INSN:    len_m1 = CNT_W'(INSN_W - 1);
         PH_RD_IDLE: len_m1 = CNT_W'(RD_IDLE_CLKS - 1);
         default:    len_m1 = CNT_W'(VIS_W - 1);
      endcase
   end
   assign last = (cnt_q == len_m1);

   isp_shift_in #(.W(CODE_W), .LSB_FIRST(LSB_FIRST)) u_code_sr (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (phase_q == PH_CODE),
      .bit_i  (dat_in),
      .next_o (code_next)
   );

   isp_shift_in #(.W(INSN_W), .LSB_FIRST(LSB_FIRST)) u_insn_sr (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (phase_q == PH_INSN),
      .bit_i  (dat_in),
      .next_o (insn_next)
   );

   isp_shift_out #(.W(VIS_W), .LSB_FIRST(LSB_FIRST)) u_vis_sr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     ((phase_q == PH_RD_IDLE) && last),
      .load_val (vis_data),
      .shift    (phase_q == PH_RD_DATA),
      .bit_o    (vis_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_FORCE;
         cnt_q   <= '0;
         oe_q    <= 1'b0;
         valid_q <= 1'b0;
         busy_q  <= 1'b0;
         err_q   <= 1'b0;
         word_q  <= '0;
      end else begin
         valid_q <= 1'b0;
         err_q   <= 1'b0;
         cnt_q   <= last ? '0 : cnt_q + 1'b1;
         unique case (phase_q)
            PH_FORCE: if (last) begin
               phase_q <= PH_INSN;
               valid_q <= 1'b1;
               word_q  <= NOP_WORD;
            end
            PH_INSN: if (last) begin
               phase_q <= PH_CODE;
               valid_q <= 1'b1;
               busy_q  <= 1'b1;
               word_q  <= insn_next;
            end
            PH_CODE: if (last) begin
               busy_q <= 1'b0;
               if (code_next == CODE_EXEC)      phase_q <= PH_INSN;
               else if (code_next == CODE_READ) phase_q <= PH_RD_IDLE;
               else                             err_q   <= 1'b1;
            end
            PH_RD_IDLE: if (last) begin
               phase_q <= PH_RD_DATA;
               oe_q    <= 1'b1;
            end
            default: if (last) begin
               phase_q <= PH_CODE;
               oe_q    <= 1'b0;
            end
         endcase
      end
   end

   assign dat_oe     = oe_q;
   assign dat_out    = oe_q & vis_bit;
   assign insn_word  = word_q;
   assign insn_valid = valid_q;
   assign exec_busy  = busy_q;
   assign code_err   = err_q;
   assign cpu_hold   = (phase_q == PH_FORCE) || (phase_q == PH_INSN);
endmodule

// File: rtl/isp_cmd_engine_chk.sv
module isp_cmd_engine_chk #(
   parameter int VIS_W = 16
) (
   input logic clk,
   input logic rst_n,
   input logic insn_valid,
   input logic cpu_hold,
   input logic exec_busy,
   input logic dat_oe,
   input logic code_err
);
   localparam int RUN_W = $clog2(VIS_W + 2);
   logic [RUN_W-1:0] oe_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      oe_run_q <= '0;
      else if (dat_oe) oe_run_q <= oe_run_q + 1'b1;
      else             oe_run_q <= '0;
   end

   p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      insn_valid |=> !insn_valid);
   p_busy_no_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      exec_busy |-> !cpu_hold);
   p_busy_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && !cpu_hold) |-> exec_busy);
   p_oe_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dat_oe) |=> dat_oe);
   p_oe_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dat_oe |-> (!cpu_hold && !insn_valid && !exec_busy));
   p_oe_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      oe_run_q <= RUN_W'(VIS_W));
   p_err_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
      code_err |-> (!insn_valid && !dat_oe && !exec_busy));
   p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      code_err |=> (!code_err && !dat_oe && !cpu_hold));
endmodule

bind isp_cmd_engine isp_cmd_engine_chk #(.VIS_W(VIS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .insn_valid (insn_valid),
   .cpu_hold   (cpu_hold),
   .exec_busy  (exec_busy),
   .dat_oe     (dat_oe),
   .code_err   (code_err)
);

// File: tb/isp_cmd_engine_test.sv
`timescale 1ns/1ps
module isp_cmd_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dat_in = 1'b0;
   logic        dat_out, dat_oe, insn_valid, cpu_hold, exec_busy, code_err;
   logic [15:0] vis_data = '0;
   logic [23:0] insn_word;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;
   bit after_exec = 1'b0;

   always #10 clk = ~clk;

   isp_cmd_engine uut (
      .clk(clk), .rst_n(rst_n), .dat_in(dat_in), .dat_out(dat_out), .dat_oe(dat_oe),
      .vis_data(vis_data), .insn_word(insn_word), .insn_valid(insn_valid),
      .cpu_hold(cpu_hold), .exec_busy(exec_busy), .code_err(code_err)
   );

   function automatic bit is_reserved(input logic [3:0] c);
      return (c != 4'd0) && (c != 4'd1);
   endfunction

   function automatic logic vis_bit_at(input logic [15:0] v, input int k);
      return v[k];
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // bench sits at a falling edge; drive, then wait past the rising edge
   task automatic send(input logic b);
      dat_in = b;
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      #7;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic forced_start(input string req);
      chk(req, "hold at reset", {31'd0, cpu_hold}, 1);
      chk(req, "valid at reset", {31'd0, insn_valid}, 0);
      chk(req, "oe at reset", {31'd0, dat_oe}, 0);
      for (int i = 0; i < 9; i++) begin
         send(1'($urandom));
         if (i < 8) chk(req, "no early valid", {31'd0, insn_valid}, 0);
      end
      chk(req, "forced valid", {31'd0, insn_valid}, 1);
      chk(req, "forced nop", {8'd0, insn_word}, 0);
      chk(req, "hold after force", {31'd0, cpu_hold}, 1);
      after_exec = 1'b0;
   endtask

   task automatic shift_insn(input logic [23:0] w);
      for (int i = 0; i < 24; i++) begin
         send(w[i]);
         if (i < 23) begin
            if (i == 5) chk("R3", "hold while loading", {31'd0, cpu_hold}, 1);
            if (i == 7) chk("R2", "valid before end", {31'd0, insn_valid}, 0);
         end
      end
      chk("R2", "valid strobe", {31'd0, insn_valid}, 1);
      chk("R2", "word", {8'd0, insn_word}, {8'd0, w});
      chk("R3", "hold released", {31'd0, cpu_hold}, 0);
      chk("R4", "busy start", {31'd0, exec_busy}, 1);
      after_exec = 1'b1;
   endtask

   task automatic send_code(input logic [3:0] c);
      for (int i = 0; i < 4; i++) begin
         send(c[i]);
         if (i < 3) begin
            chk("R4", "busy window", {31'd0, exec_busy}, {31'd0, after_exec});
            chk("R7", "no err mid code", {31'd0, code_err}, 0);
         end
      end
      chk("R4", "busy ended", {31'd0, exec_busy}, 0);
      after_exec = 1'b0;
   endtask

   task automatic do_exec(input logic [23:0] w);
      send_code(4'd0);
      chk("R3", "hold on exec code", {31'd0, cpu_hold}, 1);
      shift_insn(w);
   endtask

   task automatic do_read(input logic [15:0] v);
      vis_data = v;
      send_code(4'd1);
      chk("R3", "no hold on read", {31'd0, cpu_hold}, 0);
      for (int i = 0; i < 8; i++) begin
         send(1'($urandom));
         if (i < 7) chk("R5", "oe low in idle", {31'd0, dat_oe}, 0);
      end
      vis_data = ~v;   // must already be captured
      for (int k = 0; k < 16; k++) begin
         if (k > 0) send(1'($urandom));
         chk("R5", "oe in data", {31'd0, dat_oe}, 1);
         chk("R5", $sformatf("bit %0d", k), {31'd0, dat_out}, {31'd0, vis_bit_at(v, k)});
      end
      send(1'b0);
      chk("R6", "oe released", {31'd0, dat_oe}, 0);
   endtask

   task automatic do_reserved(input logic [3:0] c);
      send_code(c);
      chk("R7", "err flag", {31'd0, code_err}, 1);
      chk("R7", "no valid", {31'd0, insn_valid}, 0);
      chk("R7", "no oe", {31'd0, dat_oe}, 0);
      chk("R7", "no hold", {31'd0, cpu_hold}, 0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd4242));
      @(negedge clk);
      do_reset();
      forced_start("R1");
      shift_insn(24'hA5C3_7E);
      // directed corners
      do_read(16'h8001);
      do_reserved(4'd2);
      do_exec(24'hFFFFFF);
      do_reserved(4'd15);
      do_exec(24'h000001);
      do_read(16'hFFFF);
      do_exec(24'h800000);
      // constrained random commands
      for (int n = 0; n < 60; n++) begin
         int sel = int'($urandom % 8);
         if (sel < 4)      do_exec(24'($urandom));
         else if (sel < 7) do_read(16'($urandom));
         else              do_reserved(4'(2 + ($urandom % 14)));
      end
      // reset in the middle of an instruction load
      send_code(4'd0);
      for (int i = 0; i < 10; i++) send(1'b1);
      do_reset();
      forced_start("R8");
      shift_insn(24'h123456);
      // reset in the middle of a read-out data phase
      send_code(4'd1);
      for (int i = 0; i < 12; i++) send(1'b0);
      chk("R8", "oe before reset", {31'd0, dat_oe}, 1);
      do_reset();
      chk("R8", "oe after reset", {31'd0, dat_oe}, 0);
      forced_start("R8");
      shift_insn(24'h654321);
      do_read(16'h5AA5);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule